// File: doc/BRIEF.md
# Clock Event Source Decoder

This block watches a stream of 8-bit broadcast event codes, each qualified by a strobe, and turns them into eight independent source pulses. Every source keeps its own set of event codes. A source fires whenever the received code belongs to that set, so each source acts as the logical OR of its enabled events. Source 0 drives the timestamp-reset line. Sources 1 to 7 serve as general arm and trigger sources for downstream acquisition logic.

The event sets are stored as a 256-entry by 8-bit enable map. A host edits the map by writing a 16-bit configuration word. The word carries a command, a source number and an event number. Two commands change a single map bit in one cycle. Three commands (clear everything, clear one source, clear one source and then enable one event) sweep every entry of the map, one entry per cycle. While a sweep runs, the block holds `busy` high. Configuration writes that arrive during a sweep are dropped. Event strobes keep being decoded throughout a sweep, using whatever the map holds in that cycle.

Top module: `clk_event_decoder`

## Requirements
- R1: After reset all enables are clear, `busy` is low, and `src_pulse` and `ts_reset` are low.
- R2: The configuration word carries the event number in bits 15:8, the source number in bits 5:3 and the command code in bits 2:0. Bits 7:6 are ignored.
- R3: A strobe sampled at a clock edge makes `src_pulse[s]` high for exactly the following cycle, for every source s whose set contains `ev_code`. Without a strobe, `src_pulse` is zero.
- R4: `ts_reset` is high exactly when `src_pulse[0]` is high.
- R5: Command 4 adds the given event to the selected source's set. The change takes effect for strobes from the next cycle on, and other sources and events are left untouched.
- R6: Command 3 removes the given event from the selected source's set and leaves everything else alone.
- R7: Command 2 empties the selected source's set and then leaves only the given event enabled in it.
- R8: Command 1 empties the selected source's set and leaves the other sources unchanged.
- R9: Command 0 empties the sets of all eight sources.
- R10: Commands 5, 6 and 7 change nothing, and `busy` stays low after them.
- R11: Commands 0, 1 and 2 raise `busy` in the cycle after the write. `busy` then stays high for exactly 256 cycles.
- R12: A configuration write made while `busy` is high has no effect.
- R13: A strobe during a sweep is decoded against the map as it stands in that cycle. Entries already swept read as cleared, and entries not yet reached keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_stb | input | 1 | Event code valid strobe |
| ev_code | input | 8 | Received broadcast event code |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 16 | Configuration word: event, source and command |
| src_pulse | output | 8 | One-cycle pulse per source |
| ts_reset | output | 1 | Timestamp-reset pulse taken from source 0 |
| busy | output | 1 | A clearing sweep is in progress |

## Verification
A sequence of edits builds up overlapping sets. In one case, two sources share an event, so the test can tell an OR over sources apart from a single-winner decode. In another, one source holds two events, so removing one of them shows that only one bit changed. The lowest and highest event codes, on the lowest and highest sources, check the field positions and the edges of the index range. The timestamp line is checked with source 0 alone. The sweep commands are checked for the length of `busy` and for their reach: clear-one-source must spare other sources, and replace must leave exactly one event. Strobes are issued in the middle of a sweep, both on an entry that has already been cleared and on one not yet reached, so that per-cycle decoding can be told apart from a stale or atomic view of the map.

// File: rtl/evdec_pkg.sv
package evdec_pkg;
  localparam int CODE_W = 8;
  localparam int N_SRC  = 8;
  localparam int SEL_W  = $clog2(N_SRC);
  localparam int CFG_W  = 16;

  typedef enum logic [2:0] {
    CMD_CLR_ALL = 3'd0,
    CMD_CLR_SRC = 3'd1,
    CMD_REPLACE = 3'd2,
    CMD_DIS_ONE = 3'd3,
    CMD_EN_ONE  = 3'd4,
    CMD_NOP5    = 3'd5,
    CMD_NOP6    = 3'd6,
    CMD_NOP7    = 3'd7
  } cmd_e;
endpackage

// File: rtl/evdec_cfg_decode.sv
module evdec_cfg_decode
  import evdec_pkg::*;
#(
  parameter int CODE_W_P = CODE_W,
  parameter int N_SRC_P  = N_SRC,
  parameter int CFG_W_P  = CFG_W,
  localparam int SEL_W_L = $clog2(N_SRC_P)
) (
  input  logic                  cfg_wr,
  input  logic [CFG_W_P-1:0]    cfg_word,
  input  logic                  busy,
  output logic                  single_we,
  output logic                  single_val,
  output logic [CODE_W_P-1:0]   evt,
  output logic [SEL_W_L-1:0]    sel,
  output logic                  start_sweep,
  output logic [N_SRC_P-1:0]    sweep_mask,
  output logic                  sweep_set
);
  cmd_e                cmd;
  logic                accept;
  logic [N_SRC_P-1:0]  sel_onehot;

  assign cmd    = cmd_e'(cfg_word[2:0]);
  assign evt    = cfg_word[CFG_W_P-1 -: CODE_W_P];
  assign sel    = cfg_word[3 +: SEL_W_L];
  assign accept = cfg_wr && !busy;

  for (genvar s = 0; s < N_SRC_P; s++) begin : g_sel
    assign sel_onehot[s] = (sel == SEL_W_L'(s));
  end

  always_comb begin
    single_we   = 1'b0;
    single_val  = 1'b0;
    start_sweep = 1'b0;
    sweep_mask  = '0;
    sweep_set   = 1'b0;
    if (accept) begin
      unique case (cmd)
        CMD_CLR_ALL: begin
          start_sweep = 1'b1;
          sweep_mask  = '1;
        end
        CMD_CLR_SRC: begin
          start_sweep = 1'b1;
          sweep_mask  = sel_onehot;
        end
        CMD_REPLACE: begin
          start_sweep = 1'b1;
          sweep_mask  = sel_onehot;
          sweep_set   = 1'b1;
        end
        CMD_DIS_ONE: begin
          single_we  = 1'b1;
          single_val = 1'b0;
        end
        CMD_EN_ONE: begin
          single_we  = 1'b1;
          single_val = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evdec_sweep_ctrl.sv
module evdec_sweep_ctrl
  import evdec_pkg::*;
#(
  parameter int CODE_W_P = CODE_W,
  parameter int N_SRC_P  = N_SRC,
  localparam int SEL_W_L = $clog2(N_SRC_P)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_sweep,
  input  logic [N_SRC_P-1:0]    start_mask,
  input  logic                  start_set,
  input  logic [CODE_W_P-1:0]   start_evt,
  input  logic [SEL_W_L-1:0]    start_sel,
  output logic                  busy,
  output logic [CODE_W_P-1:0]   sweep_idx,
  output logic [N_SRC_P-1:0]    sweep_mask,
  output logic [N_SRC_P-1:0]    sweep_set_vec
);
  localparam logic [CODE_W_P-1:0] IDX_LAST = '1;

  logic                 busy_q, busy_d;
  logic [CODE_W_P-1:0]  idx_q, idx_d;
  logic [N_SRC_P-1:0]   mask_q, mask_d;
  logic                 set_q, set_d;
  logic [CODE_W_P-1:0]  evt_q, evt_d;
  logic [SEL_W_L-1:0]   sel_q, sel_d;
  logic                 load_en;

  assign load_en = start_sweep && !busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    mask_d = mask_q;
    set_d  = set_q;
    evt_d  = evt_q;
    sel_d  = sel_q;
    if (load_en) begin
      busy_d = 1'b1;
      idx_d  = '0;
      mask_d = start_mask;
      set_d  = start_set;
      evt_d  = start_evt;
      sel_d  = start_sel;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      mask_q <= '0;
      set_q  <= 1'b0;
      evt_q  <= '0;
      sel_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      if (load_en) begin
        mask_q <= mask_d;
        set_q  <= set_d;
        evt_q  <= evt_d;
        sel_q  <= sel_d;
      end
    end
  end

  assign busy          = busy_q;
  assign sweep_idx     = idx_q;
  assign sweep_mask    = mask_q;
  assign sweep_set_vec = (set_q && idx_q == evt_q) ? (N_SRC_P'(1) << sel_q) : '0;

  // R11: busy only rises because a sweep command was taken
  p_busy_from_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_sweep));
  // R11: one entry per cycle while sweeping
  p_idx_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != IDX_LAST) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
  // R11: sweep ends after the last entry
  p_busy_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == IDX_LAST) |=> !busy_q);
endmodule

// File: rtl/evdec_enable_map.sv
module evdec_enable_map
  import evdec_pkg::*;
#(
  parameter int CODE_W_P = CODE_W,
  parameter int N_SRC_P  = N_SRC,
  localparam int SEL_W_L = $clog2(N_SRC_P),
  localparam int DEPTH_L = 1 << CODE_W_P
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  single_we,
  input  logic                  single_val,
  input  logic [CODE_W_P-1:0]   single_addr,
  input  logic [SEL_W_L-1:0]    single_sel,
  input  logic                  sweep_we,
  input  logic [CODE_W_P-1:0]   sweep_idx,
  input  logic [N_SRC_P-1:0]    sweep_mask,
  input  logic [N_SRC_P-1:0]    sweep_set_vec,
  input  logic                  ev_stb,
  input  logic [CODE_W_P-1:0]   ev_code,
  output logic [N_SRC_P-1:0]    pulse
);
  logic [N_SRC_P-1:0] map_q [DEPTH_L];
  logic [N_SRC_P-1:0] map_d [DEPTH_L];
  logic [N_SRC_P-1:0] pulse_q, pulse_d;

  always_comb begin
    for (int r = 0; r < DEPTH_L; r++) map_d[r] = map_q[r];
    if (sweep_we) begin
      map_d[sweep_idx] = (map_q[sweep_idx] & ~sweep_mask) | sweep_set_vec;
    end else if (single_we) begin
      map_d[single_addr][single_sel] = single_val;
    end
  end

  assign pulse_d = ev_stb ? map_q[ev_code] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH_L; r++) map_q[r] <= '0;
      pulse_q <= '0;
    end else begin
      for (int r = 0; r < DEPTH_L; r++) map_q[r] <= map_d[r];
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R3: a pulse needs a strobe one cycle earlier
  p_pulse_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |-> $past(ev_stb));
  // R5: an enable lands in the addressed bit
  p_enable_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (single_we && !sweep_we && single_val) |=> map_q[$past(single_addr)][$past(single_sel)]);
  // R6: a disable lands in the addressed bit
  p_disable_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_we && !sweep_we && !single_val) |=> !map_q[$past(single_addr)][$past(single_sel)]);
  // R9: a swept entry holds only the kept bits plus the replacement bit
  p_swept_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_we |=> ((map_q[$past(sweep_idx)] & $past(sweep_mask)) == $past(sweep_set_vec)));
endmodule

// File: rtl/clk_event_decoder.sv
module clk_event_decoder
  import evdec_pkg::*;
#(
  parameter int CODE_W_P = CODE_W,
  parameter int N_SRC_P  = N_SRC,
  parameter int CFG_W_P  = CFG_W,
  localparam int SEL_W_L = $clog2(N_SRC_P)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_stb,
  input  logic [CODE_W_P-1:0]  ev_code,
  input  logic                 cfg_wr,
  input  logic [CFG_W_P-1:0]   cfg_word,
  output logic [N_SRC_P-1:0]   src_pulse,
  output logic                 ts_reset,
  output logic                 busy
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic                 single_we, single_val, start_sweep, sweep_set;
  logic [CODE_W_P-1:0]  evt, sweep_idx;
  logic [SEL_W_L-1:0]   sel;
  logic [N_SRC_P-1:0]   start_mask, sweep_mask, sweep_set_vec;

  evdec_cfg_decode #(.CODE_W_P(CODE_W_P), .N_SRC_P(N_SRC_P), .CFG_W_P(CFG_W_P)) u_dec (
    .cfg_wr      (cfg_wr),
    .cfg_word    (cfg_word),
    .busy        (busy),
    .single_we   (single_we),
    .single_val  (single_val),
    .evt         (evt),
    .sel         (sel),
    .start_sweep (start_sweep),
    .sweep_mask  (start_mask),
    .sweep_set   (sweep_set)
  );

  evdec_sweep_ctrl #(.CODE_W_P(CODE_W_P), .N_SRC_P(N_SRC_P)) u_sweep (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .start_sweep   (start_sweep),
    .start_mask    (start_mask),
    .start_set     (sweep_set),
    .start_evt     (evt),
    .start_sel     (sel),
    .busy          (busy),
    .sweep_idx     (sweep_idx),
    .sweep_mask    (sweep_mask),
    .sweep_set_vec (sweep_set_vec)
  );

  evdec_enable_map #(.CODE_W_P(CODE_W_P), .N_SRC_P(N_SRC_P)) u_map (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .single_we     (single_we),
    .single_val    (single_val),
    .single_addr   (evt),
    .single_sel    (sel),
    .sweep_we      (busy),
    .sweep_idx     (sweep_idx),
    .sweep_mask    (sweep_mask),
    .sweep_set_vec (sweep_set_vec),
    .ev_stb        (ev_stb),
    .ev_code       (ev_code),
    .pulse         (src_pulse)
  );

  assign ts_reset = src_pulse[0];

  // R12: a write during a sweep never starts anything new
  p_write_ignored_busy_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_wr && busy) |-> (!single_we && !start_sweep));
endmodule

// File: tb/tb_clk_event_decoder.sv
module tb_clk_event_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_stb = 1'b0;
  logic [7:0]  ev_code = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [7:0]  src_pulse;
  logic        ts_reset;
  logic        busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clk_event_decoder dut (
    .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_code(ev_code),
    .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .src_pulse(src_pulse), .ts_reset(ts_reset), .busy(busy)
  );

  // {cfg word, event to fire, expected pulse}; word = {event, 2'b00, source, command}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {16'h100C, 8'h10, 8'h02},  // cmd4 ev10 src1
    {16'h102C, 8'h10, 8'h22},  // cmd4 ev10 src5: OR of two sources
    {16'h200C, 8'h20, 8'h02},  // cmd4 ev20 src1
    {16'h0005, 8'h10, 8'h22},  // cmd5 no-op
    {16'h100B, 8'h10, 8'h20},  // cmd3 ev10 src1
    {16'h300A, 8'h30, 8'h02},  // cmd2 ev30 src1
    {16'h0007, 8'h20, 8'h00},  // cmd7 no-op; ev20 gone from src1
    {16'hFF04, 8'hFF, 8'h01},  // cmd4 evFF src0
    {16'h003C, 8'h00, 8'h80},  // cmd4 ev00 src7
    {16'h0029, 8'h10, 8'h00},  // cmd1 src5
    {16'h0006, 8'h30, 8'h02},  // cmd6 no-op; src1 survives
    {16'h0000, 8'hFF, 8'h00},  // cmd0
    {16'h0005, 8'h00, 8'h00}   // after cmd0, src7 gone
  };
  string VREQ [NV] = '{"R5", "R3", "R2", "R10", "R6", "R7", "R7",
                       "R4", "R2", "R8", "R8", "R9", "R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic fire(input logic [7:0] c, output logic [7:0] p, output logic t);
    @(negedge clk);
    ev_stb = 1'b1; ev_code = c;
    @(negedge clk);
    ev_stb = 1'b0;
    p = src_pulse; t = ts_reset;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] p;
    logic       t;
    int         n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1", {22'd0, src_pulse, ts_reset, busy}, 32'd0);
    fire(8'h10, p, t);
    check("R1", {24'd0, p}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] w;
      w = VEC[i][31:16];
      write_cfg(w);
      check("R11", {31'd0, busy}, {31'd0, (w[2:0] <= 3'd2)});
      wait_idle();
      fire(VEC[i][15:8], p, t);
      check(VREQ[i], {24'd0, p}, {24'd0, VEC[i][7:0]});
      check("R4", {31'd0, t}, {31'd0, VEC[i][0]});
    end

    // R3: one-cycle pulse, then nothing without strobe
    write_cfg(16'h551C);  // cmd4 ev55 src3
    fire(8'h55, p, t);
    check("R3", {24'd0, p}, 32'h08);
    @(negedge clk);
    check("R3", {24'd0, src_pulse}, 32'd0);

    // R11: busy length for a sweep
    write_cfg(16'h0019);  // cmd1 src3
    n = 0;
    while (busy) begin
      n++;
      // R12: attempt an enable in the middle of the sweep
      if (n == 20) begin cfg_wr = 1'b1; cfg_word = 16'h4414; end  // cmd4 ev44 src2
      if (n == 21) cfg_wr = 1'b0;
      @(negedge clk);
    end
    check("R11", n, 256);
    fire(8'h44, p, t);
    check("R12", {24'd0, p}, 32'd0);
    fire(8'h55, p, t);
    check("R8", {24'd0, p}, 32'd0);

    // R13: strobes during a clear-all sweep
    write_cfg(16'hF024);  // cmd4 evF0 src4
    write_cfg(16'h0234);  // cmd4 ev02 src6
    fire(8'h02, p, t);
    check("R13", {24'd0, p}, 32'h40);
    write_cfg(16'h0000);
    repeat (10) @(negedge clk);
    fire(8'h02, p, t);
    check("R13", {24'd0, p}, 32'h00);  // entry already swept
    fire(8'hF0, p, t);
    check("R13", {24'd0, p}, 32'h10);  // entry not yet reached
    check("R11", {31'd0, busy}, 32'd1);
    wait_idle();
    fire(8'hF0, p, t);
    check("R9", {24'd0, p}, 32'h00);

    // R2: bits 7:6 of the word are ignored
    write_cfg(16'h77E4);  // cmd4 ev77 src4 with bits 7:6 set
    fire(8'h77, p, t);
    check("R2", {24'd0, p}, 32'h10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule